// File: doc/BRIEF.md
# MII Receive Nibble Front-End

This block sits on the receive side of a 10/100 media-independent interface and runs on the receive clock. While the data-valid line is high, it takes one 4-bit nibble on each rising edge. Preamble nibbles are discarded until the start-of-frame delimiter nibble appears. The nibbles after it are paired into bytes and presented on a plain stream. Each byte carries a valid strobe, and the stream marks the first byte and the last byte of every frame. The last beat also carries a three-bit status word: coding error, dribble nibble and collision seen.

Outside a frame, the error line together with the data code 1110 is reported as a false-carrier pulse. A frame that ends before any delimiter is dropped and counted as a runt-preamble event. Carrier-sense and collision inputs are registered and passed on as status levels. No logic depends on the clock frequency, so the same block serves both 25 MHz and 2.5 MHz receive clocks.

The controller is a four-state machine:

- ST_IDLE waits for data-valid. It enters ST_DATA_LO if the first nibble is already the delimiter, and ST_PREAMBLE otherwise.
- ST_PREAMBLE discards nibbles. It moves to ST_DATA_LO on the delimiter, or returns to ST_IDLE when data-valid drops (runt).
- ST_DATA_LO takes the low nibble of a byte and moves to ST_DATA_HI. It returns to ST_IDLE when data-valid drops (clean end).
- ST_DATA_HI completes the byte and moves back to ST_DATA_LO. It returns to ST_IDLE when data-valid drops (dribble end).

Each completed byte is held for one pairing period, so the end flag can be attached to it.

Top module: `mii_rx_frontend`

## Requirements
- R1: Bytes are built least-significant nibble first: the first nibble of each pair after the delimiter is byte_data[3:0] and the second is byte_data[7:4].
- R2: Nibbles of value 0x5 before the delimiter nibble 0xD produce no output, and the first byte is made from the two nibbles that follow 0xD.
- R3: byte_sof is high only with the first byte of a frame. byte_eof is high together with the last byte, in the cycle after the clock edge that first samples rx_dv low.
- R4: If rx_er is high on any edge where rx_dv is high in a frame, frame_status[0] (coding error) is set on the end beat.
- R5: If rx_dv drops after an odd number of post-delimiter nibbles, frame_status[1] (dribble) is set and the unpaired nibble is not output.
- R6: false_carrier pulses for one cycle after an edge that samples rx_dv low, rx_er high and rxd equal to 4'b1110. No frame is started, and other codes give no pulse.
- R7: If rx_dv drops before any delimiter, runt_preamble pulses for one cycle and no byte or end beat is produced. runt_count increments on each such event and saturates at 2^CNT_W-1.
- R8: carrier_active and collision follow crs_in and col_in with one cycle of delay, holding for as long as the inputs hold.
- R9: If col_in is high on any edge where rx_dv is high in a frame, frame_status[2] (collision seen) is set on the end beat.
- R10: A frame that ends after the delimiter with no complete byte gives an end beat with byte_eof high and byte_valid low.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rxd | input | 4 | Receive nibble |
| rx_er | input | 1 | Receive error |
| crs_in | input | 1 | Carrier sense from the line |
| col_in | input | 1 | Collision from the line |
| byte_valid | output | 1 | byte_data holds a frame byte |
| byte_data | output | 8 | Frame byte |
| byte_sof | output | 1 | First byte of frame |
| byte_eof | output | 1 | End beat of frame |
| frame_status | output | 3 | {collision seen, dribble, coding error}, valid with byte_eof |
| false_carrier | output | 1 | False-carrier pulse |
| runt_preamble | output | 1 | Runt-preamble pulse |
| runt_count | output | 8 | Saturating runt-preamble count |
| carrier_active | output | 1 | Registered carrier sense |
| collision | output | 1 | Registered collision |

## Verification
On every cycle, the assertions check the stream's framing rules. A start flag never appears without a byte. End beats appear only right after data-valid falls, and bytes appear only while a frame is arriving. They also check that false-carrier pulses have the 1110 cause, that runt pulses are silent on the stream, that collision tracks its input and that the counter never wraps. Only the bench scenarios can show the byte values and their nibble order, the preamble stripping, and the exact status bits for errored, dribbling and colliding frames. The same holds for zero-byte frames and the saturation count reached after many runts.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DATA_LO,
        ST_DATA_HI
    } rx_state_e;

    typedef struct packed {
        logic col_seen;
        logic dribble;
        logic code_err;
    } rx_status_t;

    localparam logic [3:0] NIB_DELIM = 4'hD;
    localparam logic [3:0] NIB_FCAR  = 4'hE;

endpackage

// File: rtl/mii_rx_line_sync.sv
module mii_rx_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic crs_in,
    input  logic col_in,
    output logic carrier_active,
    output logic collision
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier_active <= 1'b0;
            collision      <= 1'b0;
        end else begin
            carrier_active <= crs_in;
            collision      <= col_in;
        end
    end

    AST_COL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_in) |=> collision); // R8

endmodule

// File: rtl/mii_rx_event_ctr.sv
module mii_rx_event_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R7

endmodule

// File: rtl/mii_rx_frontend.sv
module mii_rx_frontend #(
    parameter int NIB_W = 4,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_dv,
    input  logic [NIB_W-1:0]   rxd,
    input  logic               rx_er,
    input  logic               crs_in,
    input  logic               col_in,
    output logic               byte_valid,
    output logic [2*NIB_W-1:0] byte_data,
    output logic               byte_sof,
    output logic               byte_eof,
    output logic [2:0]         frame_status,
    output logic               false_carrier,
    output logic               runt_preamble,
    output logic [CNT_W-1:0]   runt_count,
    output logic               carrier_active,
    output logic               collision
);
    import mii_rx_pkg::*;

    localparam int BYTE_W = 2 * NIB_W;

    rx_state_e         state_q, state_d;
    logic [NIB_W-1:0]  lo_nib_q;
    logic [BYTE_W-1:0] pend_data_q;
    logic              pend_valid_q, pend_sof_q;
    logic              err_q, col_q;
    logic              frame_start, frame_end, runt_evt, byte_done, fcar_evt;
    rx_status_t        end_status;

    assign frame_start = (state_q == ST_IDLE) && rx_dv;
    assign frame_end   = ((state_q == ST_DATA_LO) || (state_q == ST_DATA_HI)) && !rx_dv;
    assign runt_evt    = (state_q == ST_PREAMBLE) && !rx_dv;
    assign byte_done   = (state_q == ST_DATA_HI) && rx_dv;
    assign fcar_evt    = !rx_dv && rx_er && (rxd == NIB_W'(NIB_FCAR));

    always_comb begin
        end_status.col_seen = col_q;
        end_status.dribble  = (state_q == ST_DATA_HI);
        end_status.code_err = err_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_dv)
                    state_d = (rxd == NIB_W'(NIB_DELIM)) ? ST_DATA_LO : ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
                if (!rx_dv)
                    state_d = ST_IDLE;
                else if (rxd == NIB_W'(NIB_DELIM))
                    state_d = ST_DATA_LO;
            end
            ST_DATA_LO: state_d = rx_dv ? ST_DATA_HI : ST_IDLE;
            ST_DATA_HI: state_d = rx_dv ? ST_DATA_LO : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            byte_sof      <= 1'b0;
            byte_eof      <= 1'b0;
            frame_status  <= '0;
            false_carrier <= 1'b0;
            runt_preamble <= 1'b0;
            lo_nib_q      <= '0;
            pend_data_q   <= '0;
            pend_valid_q  <= 1'b0;
            pend_sof_q    <= 1'b0;
            err_q         <= 1'b0;
            col_q         <= 1'b0;
        end else begin
            byte_valid    <= 1'b0;
            byte_sof      <= 1'b0;
            byte_eof      <= 1'b0;
            frame_status  <= '0;
            false_carrier <= fcar_evt;
            runt_preamble <= runt_evt;

            if (frame_start) begin
                err_q        <= rx_er;
                col_q        <= col_in;
                pend_valid_q <= 1'b0;
            end else if (rx_dv) begin
                err_q <= err_q | rx_er;
                col_q <= col_q | col_in;
            end

            if ((state_q == ST_DATA_LO) && rx_dv)
                lo_nib_q <= rxd;

            if (byte_done) begin
                if (pend_valid_q) begin
                    byte_valid <= 1'b1;
                    byte_data  <= pend_data_q;
                    byte_sof   <= pend_sof_q;
                end
                pend_data_q  <= {rxd, lo_nib_q};
                pend_sof_q   <= !pend_valid_q;
                pend_valid_q <= 1'b1;
            end

            if (frame_end) begin
                byte_valid   <= pend_valid_q;
                byte_data    <= pend_data_q;
                byte_sof     <= pend_valid_q && pend_sof_q;
                byte_eof     <= 1'b1;
                frame_status <= end_status;
                pend_valid_q <= 1'b0;
            end
        end
    end

    mii_rx_event_ctr #(.CNT_W(CNT_W)) u_runt_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (runt_evt),
        .count (runt_count)
    );

    mii_rx_line_sync u_line_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .crs_in         (crs_in),
        .col_in         (col_in),
        .carrier_active (carrier_active),
        .collision      (collision)
    );

    AST_SOF_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sof |-> byte_valid); // R3

    AST_EOF_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        byte_eof |-> (!$past(rx_dv) && $past(rx_dv, 2))); // R3

    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_eof) |-> $past(rx_dv)); // R3

    AST_FCAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        false_carrier |-> $past(!rx_dv && rx_er && rxd == NIB_W'(NIB_FCAR))); // R6

    AST_RUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        runt_preamble |-> (!byte_eof && !byte_valid)); // R7

endmodule

// File: tb/mii_rx_frontend_tb.sv
`timescale 1ns/1ps
module mii_rx_frontend_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_dv, rx_er, crs_in, col_in;
    logic [3:0] rxd;
    logic       byte_valid, byte_sof, byte_eof, false_carrier, runt_preamble;
    logic       carrier_active, collision;
    logic [7:0] byte_data, runt_count;
    logic [2:0] frame_status;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] cap_data [0:15];
    logic       cap_sof  [0:15];
    int         cap_n;

    always #4 clk = ~clk;

    mii_rx_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
        .crs_in(crs_in), .col_in(col_in), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_sof(byte_sof), .byte_eof(byte_eof),
        .frame_status(frame_status), .false_carrier(false_carrier),
        .runt_preamble(runt_preamble), .runt_count(runt_count),
        .carrier_active(carrier_active), .collision(collision)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic dv, input logic [3:0] d, input logic er, input logic col);
        rx_dv = dv; rxd = d; rx_er = er; col_in = col;
        @(posedge clk);
        #1;
        if (byte_valid && cap_n < 16) begin
            cap_data[cap_n] = byte_data;
            cap_sof[cap_n]  = byte_sof;
            cap_n++;
        end
    endtask

    task automatic preamble(input int n);
        cap_n = 0;
        for (int i = 0; i < n; i++) step(1'b1, 4'h5, 1'b0, 1'b0);
        step(1'b1, 4'hD, 1'b0, 1'b0);
        check("R2 no output in preamble", cap_n, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic er, input logic col);
        step(1'b1, b[3:0], er, col);
        step(1'b1, b[7:4], er, col);
    endtask

    task automatic t_reset;
        check("R11 byte_valid", byte_valid, 0);
        check("R11 byte_eof", byte_eof, 0);
        check("R11 runt_count", runt_count, 0);
        check("R11 status", frame_status, 0);
        check("R11 collision", collision, 0);
    endtask

    task automatic t_normal;
        logic [7:0] exp_b [0:3];
        exp_b[0] = 8'h12; exp_b[1] = 8'hA5; exp_b[2] = 8'h3C; exp_b[3] = 8'hFF;
        preamble(7);
        for (int i = 0; i < 4; i++) send_byte(exp_b[i], 1'b0, 1'b0);
        check("R3 no eof while dv high", byte_eof, 0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R3 eof after dv fall", byte_eof, 1);
        check("R3 last byte with eof", byte_valid, 1);
        check("R4 R5 R9 clean status", frame_status, 0);
        check("R1 R2 byte count", cap_n, 4);
        for (int i = 0; i < 4; i++) begin
            check("R1 byte value", cap_data[i], exp_b[i]);
            check("R3 sof only first", cap_sof[i], (i == 0) ? 1 : 0);
        end
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R3 eof single cycle", byte_eof, 0);
    endtask

    task automatic t_error;
        preamble(3);
        send_byte(8'h01, 1'b0, 1'b0);
        send_byte(8'h02, 1'b1, 1'b0);
        send_byte(8'h03, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R4 coding error status", frame_status, 3'b001);
        check("R4 bytes still delivered", cap_n, 3);
    endtask

    task automatic t_dribble;
        preamble(2);
        send_byte(8'h9A, 1'b0, 1'b0);
        send_byte(8'h5B, 1'b0, 1'b0);
        send_byte(8'h6C, 1'b0, 1'b0);
        step(1'b1, 4'h7, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R5 dribble status", frame_status, 3'b010);
        check("R5 partial dropped count", cap_n, 3);
        check("R5 last full byte", cap_data[2], 8'h6C);
    endtask

    task automatic t_collision;
        preamble(2);
        send_byte(8'h11, 1'b0, 1'b1);
        send_byte(8'h22, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R9 collision seen", frame_status, 3'b100);
    endtask

    task automatic t_false_carrier;
        cap_n = 0;
        step(1'b0, 4'hE, 1'b1, 1'b0);
        check("R6 false carrier pulse", false_carrier, 1);
        check("R6 no frame end", byte_eof, 0);
        step(1'b0, 4'hF, 1'b1, 1'b0);
        check("R6 other code no pulse", false_carrier, 0);
        step(1'b0, 4'hE, 1'b0, 1'b0);
        check("R6 no error no pulse", false_carrier, 0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R6 no bytes", cap_n, 0);
    endtask

    task automatic t_runt;
        cap_n = 0;
        step(1'b1, 4'h5, 1'b0, 1'b0);
        step(1'b1, 4'h5, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R7 runt pulse", runt_preamble, 1);
        check("R7 no eof on runt", byte_eof, 0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R7 runt count one", runt_count, 1);
        check("R7 no bytes", cap_n, 0);
    endtask

    task automatic t_runt_saturate;
        for (int i = 0; i < 260; i++) begin
            step(1'b1, 4'h5, 1'b0, 1'b0);
            step(1'b0, 4'h0, 1'b0, 1'b0);
        end
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R7 saturated count", runt_count, 255);
    endtask

    task automatic t_empty;
        preamble(1);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R10 empty eof", byte_eof, 1);
        check("R10 empty no byte", byte_valid, 0);
        check("R10 empty status", frame_status, 0);
        preamble(1);
        step(1'b1, 4'h3, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R10 one nibble eof", byte_eof, 1);
        check("R10 one nibble no byte", byte_valid, 0);
        check("R5 one nibble dribble", frame_status, 3'b010);
    endtask

    task automatic t_lines;
        crs_in = 1'b1;
        step(1'b0, 4'h0, 1'b0, 1'b1);
        check("R8 carrier on", carrier_active, 1);
        check("R8 collision on", collision, 1);
        step(1'b0, 4'h0, 1'b0, 1'b1);
        check("R8 collision held", collision, 1);
        crs_in = 1'b0;
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R8 carrier off", carrier_active, 0);
        check("R8 collision off", collision, 0);
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_dv = 1'b0; rxd = 4'h0; rx_er = 1'b0;
        crs_in = 1'b0; col_in = 1'b0; cap_n = 0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_error();
        t_dribble();
        t_collision();
        t_false_carrier();
        t_runt();
        t_empty();
        t_lines();
        t_runt_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule